// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines and presents a single interrupt output to a host processor. It keeps three 8-bit registers. The request register samples the lines every clock. The mask register blocks chosen lines. The in-service register records which acknowledged interrupts are still being handled. A priority resolver picks the winning line, either in a fixed order or in a rotating order.

The host reaches the block through a small bus made of a chip select, read and write strobes, one address bit and an 8-bit data path. The address bit picks the command port or the data port.

An acknowledge pulse from the host moves the winning request into service. The block answers one cycle later with a vector made of a programmable 5-bit base and the 3-bit line number. A cascade strobe goes out with the vector when line 2 wins, so a second controller on line 2 can drive its own vector. Two controllers give fifteen usable inputs.

Top module: `irqPrioTop`

## Requirements
- R1: After reset the mask reads 0xFF, `intOut` and `vecValid` are low, fixed priority is active and command-port reads return the request register.
- R2: With `addr` high, a write loads the mask register and a read returns it. With `addr` low, the access goes to the command port. `dataOut` is zero whenever no read is in progress.
- R3: A mask bit at 1 keeps its line from raising `intOut` or winning an acknowledge. Unmasked lines keep working, and the request register still shows the masked line.
- R4: A command write with bit 4 clear and bit 3 set is the read-select command. Value 0x0A selects the request register and 0x0B selects the in-service register for command-port reads. The selection stays in force until the next read-select command.
- R5: `intOut` is high exactly when some unmasked pending request ranks strictly above the highest-ranked set in-service bit, or when such a request exists and no in-service bit is set.
- R6: In fixed mode line 0 ranks highest and line 7 lowest.
- R7: When `intAck` is high at a clock edge and a request qualifies under R5, the winning line's in-service bit is set. On the next cycle `vecValid` pulses with `vecOut` = {base, line}.
- R8: When `intAck` arrives and no request qualifies (the request was withdrawn), `vecValid` still pulses, with `vecOut` = {base, 3'd7}, and no in-service bit changes.
- R9: The command 0x20 (bits 4 and 3 clear, bit 5 set) is a non-specific end-of-interrupt. It clears the highest-ranked set in-service bit.
- R10: A command write with bit 4 set is the mode command. Its bit 0 selects rotating priority (1) or fixed priority (0), and it resets the rotation so that line 7 ranks lowest. In rotating mode each end-of-interrupt makes the line it cleared the lowest-ranked line.
- R11: The first data-port write after a mode command loads the vector base from bits 7..3 and leaves the mask unchanged. The reset base is 0.
- R12: `casSel` pulses together with `vecValid` only when line 2 is the acknowledged line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 1 | Port select: 0 command, 1 data |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data |
| irqIn | input | 8 | Level interrupt request lines |
| intAck | input | 1 | Interrupt acknowledge pulse |
| intOut | output | 1 | Interrupt request to host |
| vecOut | output | 8 | Vector for the acknowledged line |
| vecValid | output | 1 | Vector valid pulse |
| casSel | output | 1 | Cascade select for line 2 |

## Verification
A corrupted in-service register shows up right away in two places. First, `intOut` is wrong for nesting: a lower line breaks in, or a higher one is held off. Second, the next read after selecting the in-service register returns the wrong value. A wrong rotation pointer produces a wrong vector on the very next acknowledge in which two lines compete. A lost read selection or a lost base appears on the following command-port read or on the following vector. The bench compares every vector and cascade strobe against a queue of expected values, and it reads both status registers back after each acknowledge and each end-of-interrupt.

// File: rtl/irqPrioPkg.sv
package irqPrioPkg;
  localparam int NUM_LINES = 8;
  localparam int DATA_W = 8;
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int BASE_W = DATA_W - LINE_W;
  localparam int CASC_LINE = 2;

  typedef logic [NUM_LINES-1:0] lineVec_t;
  typedef logic [LINE_W-1:0] lineIdx_t;

  typedef struct packed {
    logic maskWr;
    logic baseWr;
    logic eoi;
    logic ack;
    logic modeWr;
  } strobe_t;

  // bit r of the result is line (r + amt) mod NUM_LINES, i.e. rank r
  function automatic lineVec_t rotDown(lineVec_t v, lineIdx_t amt);
    logic [2*NUM_LINES-1:0] d;
    d = {v, v} >> amt;
    return d[NUM_LINES-1:0];
  endfunction

  // index of lowest set bit, NUM_LINES when empty
  function automatic logic [LINE_W:0] firstSet(lineVec_t v);
    logic [LINE_W:0] r;
    r = (LINE_W+1)'(NUM_LINES);
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = (LINE_W+1)'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irqPrioCtrl.sv
module irqPrioCtrl
  import irqPrioPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              intAck,
  output strobe_t           stb,
  output logic              readIsr,
  output logic              rotateEn,
  output logic              rdEn
);
  logic cmdWr, dataWr, modeCmd, selCmd, eoiCmd, expectBase;

  assign cmdWr   = cs & wr & ~addr;
  assign dataWr  = cs & wr & addr;
  assign modeCmd = cmdWr & dataIn[4];
  assign selCmd  = cmdWr & ~dataIn[4] & dataIn[3];
  assign eoiCmd  = cmdWr & ~dataIn[4] & ~dataIn[3] & dataIn[5];
  assign rdEn    = cs & rd;

  always_comb begin
    stb.maskWr = dataWr & ~expectBase;
    stb.baseWr = dataWr & expectBase;
    stb.eoi    = eoiCmd;
    stb.ack    = intAck;
    stb.modeWr = modeCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expectBase <= 1'b0;
      rotateEn   <= 1'b0;
      readIsr    <= 1'b0;
    end else begin
      if (modeCmd) begin
        expectBase <= 1'b1;
        rotateEn   <= dataIn[0];
      end else if (dataWr) begin
        expectBase <= 1'b0;
      end
      if (selCmd && dataIn[1]) readIsr <= dataIn[0];
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !selCmd |=> $stable(readIsr)); // R4
  AST_BASE_NOT_MASK: assert property (@(posedge clk) disable iff (!rstN)
    modeCmd |=> !stb.maskWr); // R11
endmodule

// File: rtl/irqPrioData.sv
module irqPrioData
  import irqPrioPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  lineVec_t          irqIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rotateEn,
  input  logic              readIsr,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic              intOut,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid,
  output logic              casSel,
  output logic [DATA_W-1:0] rdData
);
  lineVec_t irr, mask, isr, isrNext, pend;
  lineIdx_t ptr, lowest, start, grantLine, eoiLine;
  logic [BASE_W-1:0] base;
  logic [LINE_W:0] pRank, iRank;
  logic grantValid, eoiValid;

  always_comb begin
    lowest     = rotateEn ? ptr : lineIdx_t'(NUM_LINES - 1);
    start      = lowest + 1'b1;
    pend       = irr & ~mask;
    pRank      = firstSet(rotDown(pend, start));
    iRank      = firstSet(rotDown(isr, start));
    grantValid = pRank < iRank;
    grantLine  = pRank[LINE_W-1:0] + start;
    eoiValid   = !iRank[LINE_W];
    eoiLine    = iRank[LINE_W-1:0] + start;
    isrNext    = isr;
    if (stb.ack && grantValid) isrNext[grantLine] = 1'b1;
    if (stb.eoi && eoiValid)   isrNext[eoiLine] = 1'b0;
  end

  assign intOut = grantValid;
  assign rdData = !rdEn ? '0 : (rdAddr ? mask : (readIsr ? isr : irr));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr      <= '0;
      mask     <= '1;
      isr      <= '0;
      ptr      <= lineIdx_t'(NUM_LINES - 1);
      base     <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
      casSel   <= 1'b0;
    end else begin
      irr      <= irqIn;
      isr      <= isrNext;
      vecValid <= stb.ack;
      casSel   <= 1'b0;
      if (stb.maskWr) mask <= wrData[NUM_LINES-1:0];
      if (stb.baseWr) base <= wrData[DATA_W-1:LINE_W];
      if (stb.ack) begin
        if (grantValid) begin
          vecOut <= {base, grantLine};
          casSel <= (grantLine == lineIdx_t'(CASC_LINE));
        end else begin
          vecOut <= {base, lineIdx_t'(NUM_LINES - 1)};
        end
      end
      if (stb.modeWr) ptr <= lineIdx_t'(NUM_LINES - 1);
      else if (stb.eoi && eoiValid && rotateEn) ptr <= eoiLine;
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (irr & ~mask) != '0); // R3
  AST_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !grantValid && !stb.eoi) |=> isr == $past(isr)); // R8
  AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && grantValid && !stb.eoi) |=> $countones(isr) == $countones($past(isr)) + 1); // R7
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && isr != '0 && !stb.ack) |=> $countones(isr) + 1 == $countones($past(isr))); // R9
  AST_CAS_WITH_VEC: assert property (@(posedge clk) disable iff (!rstN)
    casSel |-> vecValid); // R12
endmodule

// File: rtl/irqPrioTop.sv
module irqPrioTop
  import irqPrioPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  input  logic [7:0] irqIn,
  input  logic       intAck,
  output logic       intOut,
  output logic [7:0] vecOut,
  output logic       vecValid,
  output logic       casSel
);
  strobe_t stb;
  logic readIsr, rotateEn, rdEn;

  irqPrioCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .dataIn(dataIn), .intAck(intAck), .stb(stb), .readIsr(readIsr),
    .rotateEn(rotateEn), .rdEn(rdEn)
  );

  irqPrioData data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .irqIn(irqIn), .wrData(dataIn),
    .rotateEn(rotateEn), .readIsr(readIsr), .rdEn(rdEn), .rdAddr(addr),
    .intOut(intOut), .vecOut(vecOut), .vecValid(vecValid), .casSel(casSel),
    .rdData(dataOut)
  );

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intAck)); // R7
endmodule

// File: tb/irqPrioTop_tb.sv
`timescale 1ns/100ps
module irqPrioTop_tb_top;
  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic intAck = 1'b0;
  logic [7:0] dataIn = '0, irqIn = '0;
  logic [7:0] dataOut, vecOut;
  logic intOut, vecValid, casSel;
  int checks = 0, fails = 0;
  logic [8:0] expQ[$];
  logic [7:0] rv;

  always #2 clk = ~clk;

  irqPrioTop dut_i (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .irqIn(irqIn), .intAck(intAck),
    .intOut(intOut), .vecOut(vecOut), .vecValid(vecValid), .casSel(casSel)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic portWr(input logic a, input logic [7:0] v);
    @(negedge clk); cs = 1'b1; wr = 1'b1; addr = a; dataIn = v;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
  endtask

  task automatic portRd(input logic a, output logic [7:0] v);
    @(negedge clk); cs = 1'b1; rd = 1'b1; addr = a;
    #1 v = dataOut;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk); irqIn = v;
    @(negedge clk);
  endtask

  // driver: pushes the expected {casSel, vecOut}
  task automatic doAck(input logic [7:0] vec, input logic cas);
    @(negedge clk); intAck = 1'b1; expQ.push_back({cas, vec});
    @(negedge clk); intAck = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      if (expQ.size() == 0) chk("R7 unexpected vector", {casSel, vecOut}, 9'h1FF);
      else chk("R7/R8/R12 vector", {casSel, vecOut}, expQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 intOut", {8'b0, intOut}, 9'h0);
    chk("R1 vecValid", {8'b0, vecValid}, 9'h0);
    portRd(1'b1, rv); chk("R1 mask", {1'b0, rv}, 9'hFF);
    portRd(1'b0, rv); chk("R1 irr sel", {1'b0, rv}, 9'h00);
    #1 chk("R2 idle dataOut", {1'b0, dataOut}, 9'h00);

    setIrq(8'h08);
    chk("R3 masked line", {8'b0, intOut}, 9'h0);
    portRd(1'b0, rv); chk("R4 irr default", {1'b0, rv}, 9'h08);

    portWr(1'b0, 8'h10); portWr(1'b1, 8'h40);
    portRd(1'b1, rv); chk("R11 mask kept", {1'b0, rv}, 9'hFF);
    portWr(1'b1, 8'h00);
    portRd(1'b1, rv); chk("R2 mask write", {1'b0, rv}, 9'h00);
    chk("R5 raise", {8'b0, intOut}, 9'h1);

    setIrq(8'h88);
    doAck(8'h43, 1'b0); // R6 line 3 beats line 7
    chk("R5 lower held", {8'b0, intOut}, 9'h0);
    portWr(1'b0, 8'h0B);
    portRd(1'b0, rv); chk("R4 isr sel", {1'b0, rv}, 9'h08);
    portRd(1'b0, rv); chk("R4 sel held", {1'b0, rv}, 9'h08);

    setIrq(8'h8A);
    chk("R5 nest", {8'b0, intOut}, 9'h1);
    doAck(8'h41, 1'b0);
    portRd(1'b0, rv); chk("R7 isr bits", {1'b0, rv}, 9'h0A);
    portWr(1'b0, 8'h20);
    portRd(1'b0, rv); chk("R9 eoi top", {1'b0, rv}, 9'h08);
    setIrq(8'h88);
    portWr(1'b0, 8'h20);
    portRd(1'b0, rv); chk("R9 eoi last", {1'b0, rv}, 9'h00);
    chk("R5 reraise", {8'b0, intOut}, 9'h1);
    doAck(8'h43, 1'b0);
    portWr(1'b0, 8'h20);

    portWr(1'b1, 8'h08);
    chk("R3 other line", {8'b0, intOut}, 9'h1);
    doAck(8'h47, 1'b0);
    portRd(1'b0, rv); chk("R3 line7 served", {1'b0, rv}, 9'h80);
    portWr(1'b0, 8'h20);

    portWr(1'b1, 8'h00);
    setIrq(8'h10);
    chk("R5 line4", {8'b0, intOut}, 9'h1);
    @(negedge clk); irqIn = 8'h00;
    @(negedge clk);
    doAck(8'h47, 1'b0); // R8 spurious
    portRd(1'b0, rv); chk("R8 no isr", {1'b0, rv}, 9'h00);

    setIrq(8'h04);
    doAck(8'h42, 1'b1); // R12 cascade
    portWr(1'b0, 8'h20);
    portWr(1'b0, 8'h0A);
    portRd(1'b0, rv); chk("R4 back to irr", {1'b0, rv}, 9'h04);

    setIrq(8'h0A);
    portWr(1'b0, 8'h11); portWr(1'b1, 8'h40);
    portRd(1'b1, rv); chk("R11 mask kept", {1'b0, rv}, 9'h00);
    doAck(8'h41, 1'b0);
    portWr(1'b0, 8'h20);
    doAck(8'h43, 1'b0); // R10 line 1 now lowest
    portWr(1'b0, 8'h20);
    doAck(8'h41, 1'b0); // R10 line 3 now lowest
    portWr(1'b0, 8'h20);

    repeat (2) @(negedge clk);
    chk("R7 queue drained", 9'(expQ.size()), 9'h0);
    finishRun();
  end
endmodule